// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block is the command front end on the device side of a four-bank DDR SDRAM interface. On every rising clock edge it samples the clock enable, the chip select, the three command strobes, the bank address and the multiplexed address bus. It turns what it samples into a one-hot command code. It keeps the mode register, and it tracks for each bank whether the bank is idle or has a row open. All outputs are registered and take their new value on the same edge that samples the command.

The core logic reads the latched row and column addresses, the decoded burst parameters, the per-bank open flags and the low-power state. An accepted read or write can ask for auto-precharge. In that case the bank closes on its own once the burst is over, and the burst length comes from the current mode setting. Illegal sequences do not change any state. They set a protocol-error flag that stays set until reset.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: With CKE high on the previous and current edges and chip select low, the strobes {ras_n,cas_n,we_n} decode as follows: 000 mode set (code bit 1), 011 activate (bit 2), 101 read (bit 3), 100 write (bit 4), 010 precharge (bit 5), 110 burst stop (bit 6), 001 auto refresh (bit 7) and 111 no-op (bit 0). The code is shown on `cmd_code` after that edge.
- R2: With chip select high and CKE high on both edges, the code is no-op (bit 0) whatever the strobes, bank or address are, and no bank, address or mode state changes.
- R3: An activate to an idle bank opens that bank and latches A10..A0 into `row_addr`. An activate to a bank that is already open sets `proto_err` and changes no other state.
- R4: A read or write to an open bank latches A7..A0 into `col_addr` and A8 into `auto_pre`. The access is rejected, sets `proto_err` and changes no other state if any of these holds: the bank is idle, the bank has an auto-precharge pending, or no valid mode set has been accepted since reset.
- R5: An accepted access with A8 high closes its bank BL/2 edges after the access edge. With burst length 2 the bank is closed after the next edge. With burst length 4 it is closed after the second edge.
- R6: A precharge with A8 high closes every bank. A precharge with A8 low closes only the bank on BA.
- R7: A mode set reads A2..A0 as the burst length (001 = 2, 010 = 4), A3 as the burst type (0 sequential, 1 interleaved) and A6..A4 as the CAS latency (only 011 = 3). A supported key updates `burst_len`, `burst_ilv`, `cas_lat` and sets `mode_valid`. Any other key sets `proto_err` and leaves the mode outputs unchanged.
- R8: The refresh encoding gives auto refresh (bit 7) only when CKE is high on both edges. The same encoding with CKE falling from high to low gives self-refresh entry (bit 8) and raises `self_refresh`.
- R9: CKE falling from high to low without the refresh encoding gives power-down entry (bit 10) and raises `power_down`.
- R10: While CKE stays low across an edge, `cmd_code` is all zero and no command has any effect.
- R11: CKE rising from low to high gives self-refresh exit (bit 9) or power-down exit (bit 11) and clears the low-power flag. A command other than no-op or deselect on that edge is ignored and sets `proto_err`.
- R12: After reset every bank is idle, `mode_valid`, `proto_err`, `power_down`, `self_refresh` are low and `cmd_code` is zero.
- R13: `cmd_code` never has more than one bit set, and `proto_err` stays high once set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 11 | Multiplexed row/column/key address |
| cmd_code | output | 12 | One-hot decoded command |
| cmd_bank | output | 2 | Bank of the last bank-directed command |
| row_addr | output | 11 | Row of the last accepted activate |
| col_addr | output | 8 | Column of the last accepted access |
| auto_pre | output | 1 | Auto-precharge request of the last accepted access |
| burst_len | output | 3 | Programmed burst length (2 or 4) |
| burst_ilv | output | 1 | Burst type, 1 = interleaved |
| cas_lat | output | 3 | Programmed CAS latency |
| mode_valid | output | 1 | A supported mode set has been accepted |
| bank_open | output | 4 | Per-bank open-row flags |
| proto_err | output | 1 | Sticky protocol error |
| power_down | output | 1 | In power-down |
| self_refresh | output | 1 | In self-refresh |

## Verification
The bench targets the edges where CKE changes level. There it checks that the refresh encoding on a falling CKE gives self-refresh entry and not auto refresh or power-down entry. It also checks that a command sent while CKE stays low does nothing, and that a command on the exit edge is flagged rather than carried out. A decoder that looked only at the current CKE would issue the buried activate.

It times auto-precharge closure for both burst lengths. An off-by-one counter would close the bank an edge early or late.

It also sends rejected commands and then confirms at the ports that the row, column and mode outputs kept their old values. These are an activate to an open bank, an access before the mode set, an access to an idle bank and an unsupported mode key.

// File: rtl/ddrc_pkg.sv
package ddrc_pkg;

    localparam int CMD_N = 12;
    localparam int C_NOP = 0;
    localparam int C_MRS = 1;
    localparam int C_ACT = 2;
    localparam int C_RD  = 3;
    localparam int C_WR  = 4;
    localparam int C_PRE = 5;
    localparam int C_BST = 6;
    localparam int C_REF = 7;
    localparam int C_SRE = 8;
    localparam int C_SRX = 9;
    localparam int C_PDE = 10;
    localparam int C_PDX = 11;

    localparam int KEY_W = 7;

    typedef logic [CMD_N-1:0] cmd_vec_t;

    typedef enum logic [1:0] {
        LP_AWAKE = 2'd0,
        LP_PDOWN = 2'd1,
        LP_SREF  = 2'd2
    } lp_state_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] bl;
        logic       ilv;
        logic [2:0] cl;
    } mode_cfg_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] bl;
        logic       ilv;
        logic [2:0] cl;
    } mode_req_t;

    function automatic cmd_vec_t onehot(input int idx);
        cmd_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    // strobe triple {ras_n, cas_n, we_n} with chip select low
    function automatic cmd_vec_t strobe_cmd(input logic [2:0] rcw);
        cmd_vec_t v;
        case (rcw)
            3'b000:  v = onehot(C_MRS);
            3'b011:  v = onehot(C_ACT);
            3'b101:  v = onehot(C_RD);
            3'b100:  v = onehot(C_WR);
            3'b010:  v = onehot(C_PRE);
            3'b110:  v = onehot(C_BST);
            3'b001:  v = onehot(C_REF);
            default: v = onehot(C_NOP);
        endcase
        return v;
    endfunction

    function automatic mode_req_t parse_key(input logic [KEY_W-1:0] key);
        mode_req_t r;
        case (key[2:0])
            3'b001:  r.bl = 3'd2;
            3'b010:  r.bl = 3'd4;
            default: r.bl = 3'd0;
        endcase
        r.ilv = key[3];
        r.cl  = key[6:4];
        r.ok  = (r.bl != 3'd0) && (key[6:4] == 3'b011);
        return r;
    endfunction

endpackage

// File: rtl/ddrc_decode.sv
module ddrc_decode
    import ddrc_pkg::*;
(
    input  logic     cke,
    input  logic     cke_prev,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     in_sref,
    output cmd_vec_t code,
    output logic     exit_dirty
);
    logic [2:0] rcw;
    logic       is_ref;
    logic       idle_cmd;

    assign rcw      = {ras_n, cas_n, we_n};
    assign is_ref   = ~cs_n && (rcw == 3'b001);
    assign idle_cmd = cs_n || (rcw == 3'b111);

    always_comb begin
        code       = '0;
        exit_dirty = 1'b0;
        case ({cke_prev, cke})
            2'b11: code = cs_n ? onehot(C_NOP) : strobe_cmd(rcw);
            2'b10: code = is_ref ? onehot(C_SRE) : onehot(C_PDE);
            2'b01: begin
                code       = in_sref ? onehot(C_SRX) : onehot(C_PDX);
                exit_dirty = ~idle_cmd;
            end
            default: code = '0;
        endcase
    end
endmodule

// File: rtl/ddrc_mode_reg.sv
module ddrc_mode_reg
    import ddrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [KEY_W-1:0] key,
    output mode_cfg_t        cfg,
    output logic             bad
);
    mode_req_t req;

    assign req = parse_key(key);
    assign bad = wr && !req.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr && req.ok) begin
            cfg.valid <= 1'b1;
            cfg.bl    <= req.bl;
            cfg.ilv   <= req.ilv;
            cfg.cl    <= req.cl;
        end
    end
endmodule

// File: rtl/ddrc_bank.sv
module ddrc_bank #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_cmd,
    input  logic             close_cmd,
    input  logic             ap_start,
    input  logic [CNT_W-1:0] ap_len,
    output logic             is_open,
    output logic             ap_pending
);
    logic [CNT_W-1:0] cnt;

    assign ap_pending = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            cnt     <= '0;
        end else if (close_cmd) begin
            is_open <= 1'b0;
            cnt     <= '0;
        end else if (open_cmd) begin
            is_open <= 1'b1;
            cnt     <= '0;
        end else if (ap_start) begin
            cnt <= ap_len;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
                is_open <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
    import ddrc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 11,
    parameter int COL_W     = 8,
    parameter int AP_BIT    = 8,
    parameter int MAX_BL    = 4,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(MAX_BL / 2 + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ROW_W-1:0]     addr,
    output logic [CMD_N-1:0]     cmd_code,
    output logic [BA_W-1:0]      cmd_bank,
    output logic [ROW_W-1:0]     row_addr,
    output logic [COL_W-1:0]     col_addr,
    output logic                 auto_pre,
    output logic [2:0]           burst_len,
    output logic                 burst_ilv,
    output logic [2:0]           cas_lat,
    output logic                 mode_valid,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 proto_err,
    output logic                 power_down,
    output logic                 self_refresh
);
    logic      cke_q;
    lp_state_e lp_q;
    cmd_vec_t  dec;
    cmd_vec_t  cmd_q;
    logic      exit_dirty;
    mode_cfg_t mcfg;
    logic      mode_bad;

    logic [NUM_BANKS-1:0] bk_open, bk_pend, bk_act, bk_ap, bk_close, sel;
    logic                 is_acc, act_ok, acc_ok, err_now, bank_cmd;
    logic [CNT_W-1:0]     ap_len;

    logic [BA_W-1:0]  bank_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             ap_q;
    logic             err_q;

    ddrc_decode u_dec (
        .cke        (cke),
        .cke_prev   (cke_q),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .in_sref    (lp_q == LP_SREF),
        .code       (dec),
        .exit_dirty (exit_dirty)
    );

    ddrc_mode_reg u_mode (
        .clk (clk),
        .rst (rst),
        .wr  (dec[C_MRS]),
        .key (addr[KEY_W-1:0]),
        .cfg (mcfg),
        .bad (mode_bad)
    );

    assign sel      = NUM_BANKS'(1) << ba;
    assign is_acc   = dec[C_RD] | dec[C_WR];
    assign act_ok   = dec[C_ACT] & ~bk_open[ba];
    assign acc_ok   = is_acc & bk_open[ba] & ~bk_pend[ba] & mcfg.valid;
    assign bk_act   = act_ok ? sel : '0;
    assign bk_ap    = (acc_ok && addr[AP_BIT]) ? sel : '0;
    assign bk_close = dec[C_PRE] ? (addr[AP_BIT] ? '1 : sel) : '0;
    assign ap_len   = CNT_W'(mcfg.bl >> 1);
    assign bank_cmd = dec[C_ACT] | is_acc | dec[C_PRE];
    assign err_now  = (dec[C_ACT] & ~act_ok) | (is_acc & ~acc_ok)
                    | mode_bad | exit_dirty;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddrc_bank #(.CNT_W(CNT_W)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .open_cmd   (bk_act[b]),
            .close_cmd  (bk_close[b]),
            .ap_start   (bk_ap[b]),
            .ap_len     (ap_len),
            .is_open    (bk_open[b]),
            .ap_pending (bk_pend[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q  <= 1'b1;
            lp_q   <= LP_AWAKE;
            cmd_q  <= '0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            ap_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cke_q <= cke;
            cmd_q <= dec;
            err_q <= err_q | err_now;
            if (dec[C_SRE]) begin
                lp_q <= LP_SREF;
            end else if (dec[C_PDE]) begin
                lp_q <= LP_PDOWN;
            end else if (dec[C_SRX] || dec[C_PDX]) begin
                lp_q <= LP_AWAKE;
            end
            if (bank_cmd) begin
                bank_q <= ba;
            end
            if (act_ok) begin
                row_q <= addr;
            end
            if (acc_ok) begin
                col_q <= addr[COL_W-1:0];
                ap_q  <= addr[AP_BIT];
            end
        end
    end

    assign cmd_code     = cmd_q;
    assign cmd_bank     = bank_q;
    assign row_addr     = row_q;
    assign col_addr     = col_q;
    assign auto_pre     = ap_q;
    assign burst_len    = mcfg.bl;
    assign burst_ilv    = mcfg.ilv;
    assign cas_lat      = mcfg.cl;
    assign mode_valid   = mcfg.valid;
    assign bank_open    = bk_open;
    assign proto_err    = err_q;
    assign power_down   = (lp_q == LP_PDOWN);
    assign self_refresh = (lp_q == LP_SREF);
endmodule

// File: rtl/ddrc_checker.sv
module ddrc_checker
    import ddrc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 11
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cke,
    input logic [CMD_N-1:0]     cmd_code,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [ROW_W-1:0]     row_addr,
    input logic [2:0]           burst_len,
    input logic                 burst_ilv,
    input logic [2:0]           cas_lat,
    input logic                 mode_valid,
    input logic                 proto_err,
    input logic                 power_down,
    input logic                 self_refresh
);
    // R13
    code_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_code));

    // R13
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R8
    lp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(power_down && self_refresh));

    // R8
    sref_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_code[C_SRE] |-> self_refresh);

    // R3
    open_needs_act_chk: assert property (@(posedge clk) disable iff (rst)
        (|(bank_open & ~$past(bank_open))) |-> cmd_code[C_ACT]);

    // R7
    mode_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({burst_len, burst_ilv, cas_lat, mode_valid}) |-> cmd_code[C_MRS]);

    // R10
    lp_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ((power_down || self_refresh) && !cke) |=>
            ($stable(row_addr) && $stable(mode_valid) && $stable(burst_len) && cmd_code == '0));

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (bank_open == '0 && !proto_err && !mode_valid && !power_down && !self_refresh));
endmodule

bind ddr_cmd_decoder ddrc_checker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cke          (cke),
    .cmd_code     (cmd_code),
    .bank_open    (bank_open),
    .row_addr     (row_addr),
    .burst_len    (burst_len),
    .burst_ilv    (burst_ilv),
    .cas_lat      (cas_lat),
    .mode_valid   (mode_valid),
    .proto_err    (proto_err),
    .power_down   (power_down),
    .self_refresh (self_refresh)
);

// File: tb/ddr_cmd_decoder_test.sv
module ddr_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [10:0] addr = '0;
    logic [11:0] cmd_code;
    logic [1:0]  cmd_bank;
    logic [10:0] row_addr;
    logic [7:0]  col_addr;
    logic        auto_pre;
    logic [2:0]  burst_len;
    logic        burst_ilv;
    logic [2:0]  cas_lat;
    logic        mode_valid;
    logic [3:0]  bank_open;
    logic        proto_err;
    logic        power_down;
    logic        self_refresh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ddr_cmd_decoder uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .row_addr(row_addr),
        .col_addr(col_addr), .auto_pre(auto_pre), .burst_len(burst_len),
        .burst_ilv(burst_ilv), .cas_lat(cas_lat), .mode_valid(mode_valid),
        .bank_open(bank_open), .proto_err(proto_err),
        .power_down(power_down), .self_refresh(self_refresh)
    );

    localparam logic [11:0] K_NOP = 12'h001, K_MRS = 12'h002, K_ACT = 12'h004,
        K_RD = 12'h008, K_WR = 12'h010, K_PRE = 12'h020, K_BST = 12'h040,
        K_REF = 12'h080, K_SRE = 12'h100, K_SRX = 12'h200, K_PDE = 12'h400,
        K_PDX = 12'h800;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // drive at the falling edge, let the rising edge sample, look 1 ns later
    task automatic issue(input logic k, input logic c, input logic [2:0] rcw,
                         input logic [1:0] b, input logic [10:0] a);
        @(negedge clk);
        cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();                  issue(1, 0, 3'b111, 0, 0);           endtask
    task automatic mrs(input logic [10:0] k); issue(1, 0, 3'b000, 0, k);        endtask
    task automatic act(input logic [1:0] b, input logic [10:0] r); issue(1, 0, 3'b011, b, r); endtask
    task automatic rd(input logic [1:0] b, input logic [7:0] c, input logic ap);
        issue(1, 0, 3'b101, b, {2'b00, ap, c});
    endtask
    task automatic wr(input logic [1:0] b, input logic [7:0] c, input logic ap);
        issue(1, 0, 3'b100, b, {2'b00, ap, c});
    endtask
    task automatic pre(input logic [1:0] b, input logic all);
        issue(1, 0, 3'b010, b, {2'b00, all, 8'h00});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cke = 1'b1; cs_n = 1'b1;
        {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // key: CL3 sequential BL4 = 0x32, CL3 interleaved BL2 = 0x39
    task automatic t_reset();
        do_reset();
        chk("R12", "bank_open", bank_open, 0);
        chk("R12", "mode_valid", mode_valid, 0);
        chk("R12", "proto_err", proto_err, 0);
        chk("R12", "cmd_code", cmd_code, 0);
        chk("R12", "lowpower", {power_down, self_refresh}, 0);
    endtask

    task automatic t_mode();
        do_reset();
        mrs(11'h032);
        chk("R1", "mrs code", cmd_code, K_MRS);
        chk("R7", "burst_len", burst_len, 4);
        chk("R7", "burst_ilv", burst_ilv, 0);
        chk("R7", "cas_lat", cas_lat, 3);
        chk("R7", "mode_valid", mode_valid, 1);
        chk("R7", "good key err", proto_err, 0);
        mrs(11'h033);
        chk("R7", "bad bl err", proto_err, 1);
        chk("R7", "bad bl keeps len", burst_len, 4);
        do_reset();
        mrs(11'h022);
        chk("R7", "bad cl err", proto_err, 1);
        chk("R7", "bad cl no valid", mode_valid, 0);
    endtask

    task automatic t_access_err();
        do_reset();
        act(1, 11'h010);
        rd(1, 8'h44, 0);
        chk("R4", "rd before mrs err", proto_err, 1);
        chk("R4", "rd before mrs col", col_addr, 0);
        do_reset();
        mrs(11'h032);
        wr(2, 8'h55, 0);
        chk("R4", "wr idle bank err", proto_err, 1);
        chk("R4", "wr idle bank col", col_addr, 0);
    endtask

    task automatic t_act_err();
        do_reset();
        mrs(11'h032);
        act(0, 11'h5A5);
        chk("R1", "act code", cmd_code, K_ACT);
        chk("R3", "act opens", bank_open, 4'b0001);
        chk("R3", "act row", row_addr, 11'h5A5);
        act(0, 11'h123);
        chk("R3", "double act err", proto_err, 1);
        chk("R3", "double act row kept", row_addr, 11'h5A5);
    endtask

    task automatic t_rw();
        do_reset();
        mrs(11'h032);
        act(2, 11'h7FF);
        rd(2, 8'h3C, 0);
        chk("R1", "rd code", cmd_code, K_RD);
        chk("R4", "rd col", col_addr, 8'h3C);
        chk("R4", "rd ap", auto_pre, 0);
        chk("R4", "rd bank", cmd_bank, 2);
        wr(2, 8'hC3, 0);
        chk("R1", "wr code", cmd_code, K_WR);
        chk("R4", "wr col", col_addr, 8'hC3);
        chk("R4", "no err", proto_err, 0);
    endtask

    task automatic t_autopre();
        // continues from t_rw: bank 2 open, BL4
        wr(2, 8'h11, 1);
        chk("R4", "ap flag", auto_pre, 1);
        chk("R5", "bl4 open at access", bank_open[2], 1);
        nop();
        chk("R5", "bl4 open +1", bank_open[2], 1);
        nop();
        chk("R5", "bl4 closed +2", bank_open[2], 0);
        mrs(11'h039);
        chk("R7", "ilv", burst_ilv, 1);
        chk("R7", "bl2", burst_len, 2);
        act(3, 11'h001);
        rd(3, 8'h22, 1);
        chk("R5", "bl2 open at access", bank_open[3], 1);
        nop();
        chk("R5", "bl2 closed +1", bank_open[3], 0);
        chk("R5", "no err", proto_err, 0);
    endtask

    task automatic t_pre();
        do_reset();
        mrs(11'h032);
        act(0, 1); act(1, 2); act(2, 3);
        chk("R3", "three open", bank_open, 4'b0111);
        pre(1, 0);
        chk("R1", "pre code", cmd_code, K_PRE);
        chk("R6", "pre one", bank_open, 4'b0101);
        pre(3, 1);
        chk("R6", "pre all", bank_open, 4'b0000);
    endtask

    task automatic t_deselect();
        act(0, 11'h0AA);
        issue(1, 0, 3'b110, 0, 0);
        chk("R1", "bst code", cmd_code, K_BST);
        issue(1, 1, 3'b011, 1, 11'h3F0);
        chk("R2", "deselect code", cmd_code, K_NOP);
        chk("R2", "deselect banks", bank_open, 4'b0001);
        chk("R2", "deselect row", row_addr, 11'h0AA);
        issue(1, 1, 3'b000, 0, 11'h039);
        chk("R2", "deselect mode", burst_len, 4);
    endtask

    task automatic t_sref();
        pre(0, 1);
        issue(1, 0, 3'b001, 0, 0);
        chk("R8", "auto refresh", cmd_code, K_REF);
        chk("R8", "no sref", self_refresh, 0);
        issue(0, 0, 3'b001, 0, 0);
        chk("R8", "sre code", cmd_code, K_SRE);
        chk("R8", "sref flag", self_refresh, 1);
        issue(0, 0, 3'b011, 1, 11'h077);
        chk("R10", "held low code", cmd_code, 0);
        chk("R10", "held low banks", bank_open, 0);
        chk("R10", "held low row", row_addr, 11'h0AA);
        issue(1, 1, 3'b111, 0, 0);
        chk("R11", "srx code", cmd_code, K_SRX);
        chk("R11", "sref cleared", self_refresh, 0);
        chk("R11", "clean exit", proto_err, 0);
    endtask

    task automatic t_pdown();
        issue(0, 0, 3'b111, 0, 0);
        chk("R9", "pde code", cmd_code, K_PDE);
        chk("R9", "pd flag", power_down, 1);
        chk("R9", "pd not sref", self_refresh, 0);
        issue(0, 0, 3'b000, 0, 11'h039);
        chk("R10", "pd low code", cmd_code, 0);
        chk("R10", "pd mode kept", burst_len, 4);
        chk("R10", "pd no err", proto_err, 0);
        issue(1, 0, 3'b011, 1, 11'h066);
        chk("R11", "pdx code", cmd_code, K_PDX);
        chk("R11", "pd cleared", power_down, 0);
        chk("R11", "dirty exit err", proto_err, 1);
        chk("R11", "exit cmd ignored", bank_open, 0);
        nop();
        chk("R13", "err sticky", proto_err, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_mode();
        t_access_err();
        t_act_err();
        t_rw();
        t_autopre();
        t_pre();
        t_deselect();
        t_sref();
        t_pdown();
        done = 1'b1;
        finish_run();
    end
endmodule